// File: doc/BRIEF.md
# Pin-Controlled Power-Down Hold Unit

This unit sits at the pad ring of a programmable logic core. Pad inputs pass through it on their way into the core, and core output data and output enables pass through it on their way out to the pads. Two dedicated sleep pins, `sleep_a_pin` and `sleep_b_pin`, can freeze the device. A configuration bit, `cfg_sleep_en`, arms the feature. When it is armed and either sleep pin is high, the unit presents the last valid input values to the core and holds the last output data and enables at the pads. Any pin that was high-impedance on entry stays high-impedance. It also drops the core clock enable, so no core register changes state.

Both sleep pins pass through a two-flop synchroniser before they are used. When both pins have returned low, the freeze continues for a fixed number of system clocks (`RECOV_CYCLES`). Only then do live values flow again. While the feature is armed, the sleep pins are taken out of the logic path: the core sees them as constant zero and their output drivers are disabled. While the feature is disarmed, every path is transparent and the sleep pins act as ordinary logic inputs and outputs.

Top module: `pd_hold_unit`

## Requirements
- R1: With `cfg_sleep_en`=1, a sleep pin that is high at one rising clock edge drops `core_clk_en` after the next rising edge, which is the second edge of the synchroniser. Either pin alone is enough, and so are both together.
- R2: While `core_clk_en`=0, `core_in` keeps the `pad_in` value captured at the last edge before the freeze, whatever `pad_in` does.
- R3: While `core_clk_en`=0, `pad_out` keeps the `core_out` value captured at the last edge before the freeze.
- R4: While `core_clk_en`=0, `pad_oe` keeps its captured value. A bit that was 0 (high-impedance) stays 0 even when `core_oe` rises.
- R5: `core_clk_en` stays 0 for the whole of the sleep period and the whole of the recovery period.
- R6: After the last sleep pin falls, `core_clk_en` returns to 1, and live values pass again, exactly 2+`RECOV_CYCLES` rising edges later.
- R7: With `cfg_sleep_en`=1, `core_sleep_in` reads 2'b00, and `pad_sleep_oe` and `pad_sleep_out` are 2'b00, whatever the sleep pins and the core drive.
- R8: With `cfg_sleep_en`=0, `core_in`=`pad_in`, `pad_out`=`core_out`, `pad_oe`=`core_oe`, `core_sleep_in`={`sleep_b_pin`,`sleep_a_pin`}, `pad_sleep_out`=`core_sleep_out` and `pad_sleep_oe`=`core_sleep_oe`. `core_clk_en` stays 1 even when a sleep pin is high.
- R9: During and right after reset, `core_clk_en`=1 and all paths are transparent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sleep_en | input | 1 | Configuration bit that arms the sleep feature |
| sleep_a_pin | input | 1 | First sleep pin (asynchronous) |
| sleep_b_pin | input | 1 | Second sleep pin (asynchronous) |
| pad_in | input | N_IN | Input pad values |
| core_in | output | N_IN | Input values presented to the core |
| core_out | input | N_IO | Output data from the core |
| core_oe | input | N_IO | Output enables from the core |
| pad_out | output | N_IO | Output data to the pads |
| pad_oe | output | N_IO | Output enables to the pads |
| core_sleep_in | output | 2 | Sleep pins as logic inputs to the core ({b,a}) |
| core_sleep_out | input | 2 | Core data for the sleep pins' drivers |
| core_sleep_oe | input | 2 | Core enables for the sleep pins' drivers |
| pad_sleep_out | output | 2 | Data to the sleep pins' drivers |
| pad_sleep_oe | output | 2 | Enables for the sleep pins' drivers |
| core_clk_en | output | 1 | Core clock enable; 0 while frozen |

## Verification
The hardest situation to reach from the ports is the boundary of the recovery window: the cycle in which a frozen value must still be shown and the very next cycle in which live values must appear. The stimulus drives every input, output and enable pattern of a 4-bit configuration. For each pattern it enters sleep through pin A, pin B or both, then inverts all core-side and pad-side inputs while frozen. After releasing the pins, it counts edges, so that the last held cycle and the first live cycle are both checked against values the bench derives from the pattern index.

// File: rtl/pd_hold_unit.sv
module pd_hold_unit #(
  parameter int N_IN         = 8,
  parameter int N_IO         = 8,
  parameter int RECOV_CYCLES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_sleep_en,
  input  logic            sleep_a_pin,
  input  logic            sleep_b_pin,
  input  logic [N_IN-1:0] pad_in,
  output logic [N_IN-1:0] core_in,
  input  logic [N_IO-1:0] core_out,
  input  logic [N_IO-1:0] core_oe,
  output logic [N_IO-1:0] pad_out,
  output logic [N_IO-1:0] pad_oe,
  output logic [1:0]      core_sleep_in,
  input  logic [1:0]      core_sleep_out,
  input  logic [1:0]      core_sleep_oe,
  output logic [1:0]      pad_sleep_out,
  output logic [1:0]      pad_sleep_oe,
  output logic            core_clk_en
);

  localparam int CW = (RECOV_CYCLES < 1) ? 1 : $clog2(RECOV_CYCLES + 1);
  localparam logic [CW-1:0] RECOV_LOAD = CW'(RECOV_CYCLES);

  logic [1:0]      sync1, sync2;
  logic [CW-1:0]   recov_cnt;
  logic [N_IN-1:0] in_hold;
  logic [N_IO-1:0] out_hold, oe_hold;
  logic            sleep_req, freeze;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= {sleep_b_pin, sleep_a_pin};
      sync2 <= sync1;
    end
  end

  assign sleep_req = cfg_sleep_en & (|sync2);
  assign freeze    = cfg_sleep_en & (sleep_req | (recov_cnt != '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      recov_cnt <= '0;
    else if (sleep_req)
      recov_cnt <= RECOV_LOAD;
    else if (recov_cnt != '0)
      recov_cnt <= recov_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_hold  <= '0;
      out_hold <= '0;
      oe_hold  <= '0;
    end else if (!freeze) begin
      in_hold  <= pad_in;
      out_hold <= core_out;
      oe_hold  <= core_oe;
    end
  end

  assign core_in     = freeze ? in_hold  : pad_in;
  assign pad_out     = freeze ? out_hold : core_out;
  assign pad_oe      = freeze ? oe_hold  : core_oe;
  assign core_clk_en = ~freeze;

  assign core_sleep_in = cfg_sleep_en ? 2'b00 : {sleep_b_pin, sleep_a_pin};
  assign pad_sleep_out = cfg_sleep_en ? 2'b00 : core_sleep_out;
  assign pad_sleep_oe  = cfg_sleep_en ? 2'b00 : core_sleep_oe;

endmodule

// File: rtl/pd_hold_unit_chk.sv
module pd_hold_unit_chk #(
  parameter int N_IN = 8,
  parameter int N_IO = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_sleep_en,
  input logic            sleep_a_pin,
  input logic            sleep_b_pin,
  input logic [N_IN-1:0] pad_in,
  input logic [N_IN-1:0] core_in,
  input logic [N_IO-1:0] core_out,
  input logic [N_IO-1:0] core_oe,
  input logic [N_IO-1:0] pad_out,
  input logic [N_IO-1:0] pad_oe,
  input logic [1:0]      core_sleep_in,
  input logic [1:0]      pad_sleep_out,
  input logic [1:0]      pad_sleep_oe,
  input logic            core_clk_en
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;
  end

  AST_ENTRY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && cfg_sleep_en && $past(cfg_sleep_en) && ($past(sleep_a_pin, 2) || $past(sleep_b_pin, 2))) |-> !core_clk_en); // R1
  AST_IN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && !core_clk_en && $past(!core_clk_en)) |-> $stable(core_in)); // R2
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && !core_clk_en && $past(!core_clk_en)) |-> $stable(pad_out)); // R3
  AST_OE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && !core_clk_en && $past(!core_clk_en)) |-> $stable(pad_oe)); // R4
  AST_SLEEP_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sleep_en |-> (core_sleep_in == 2'b00 && pad_sleep_oe == 2'b00 && pad_sleep_out == 2'b00)); // R7
  AST_DISARMED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_sleep_en) |-> (core_clk_en && core_in == pad_in && pad_out == core_out && pad_oe == core_oe)); // R8
endmodule

bind pd_hold_unit pd_hold_unit_chk #(.N_IN(N_IN), .N_IO(N_IO)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_sleep_en(cfg_sleep_en),
  .sleep_a_pin(sleep_a_pin), .sleep_b_pin(sleep_b_pin),
  .pad_in(pad_in), .core_in(core_in), .core_out(core_out), .core_oe(core_oe),
  .pad_out(pad_out), .pad_oe(pad_oe), .core_sleep_in(core_sleep_in),
  .pad_sleep_out(pad_sleep_out), .pad_sleep_oe(pad_sleep_oe),
  .core_clk_en(core_clk_en)
);

// File: tb/pd_hold_unit_tb_top.sv
module pd_hold_unit_tb_top;
  localparam int NI = 4;
  localparam int NO = 4;
  localparam int RC = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_sleep_en = 1'b0;
  logic sleep_a_pin = 1'b0, sleep_b_pin = 1'b0;
  logic [NI-1:0] pad_in = '0;
  logic [NO-1:0] core_out = '0, core_oe = '0;
  logic [1:0] core_sleep_out = '0, core_sleep_oe = '0;
  logic [NI-1:0] core_in;
  logic [NO-1:0] pad_out, pad_oe;
  logic [1:0] core_sleep_in, pad_sleep_out, pad_sleep_oe;
  logic core_clk_en;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pd_hold_unit #(.N_IN(NI), .N_IO(NO), .RECOV_CYCLES(RC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_sleep_en(cfg_sleep_en),
    .sleep_a_pin(sleep_a_pin), .sleep_b_pin(sleep_b_pin),
    .pad_in(pad_in), .core_in(core_in), .core_out(core_out), .core_oe(core_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .core_sleep_in(core_sleep_in),
    .core_sleep_out(core_sleep_out), .core_sleep_oe(core_sleep_oe),
    .pad_sleep_out(pad_sleep_out), .pad_sleep_oe(pad_sleep_oe),
    .core_clk_en(core_clk_en));

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  function automatic logic [3:0] oe_of(input int p);
    return {p[1:0], p[3:2]};
  endfunction

  task automatic drive(input logic [3:0] v, input logic [3:0] oe);
    pad_in = v; core_out = v; core_oe = oe;
  endtask

  task automatic chk_live(input string req, input logic [3:0] v, input logic [3:0] oe);
    #1;
    chk(req, {core_in, pad_out, pad_oe}, {v, v, oe});
  endtask

  initial begin
    #150000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    drive(4'h5, 4'hA);
    #5;
    chk("R9 reset clk_en", core_clk_en, 1);
    chk_live("R9 reset transparent", 4'h5, 4'hA);
    step(); step();
    rst_n = 1'b1;
    step();
    chk("R9 after reset clk_en", core_clk_en, 1);

    // Disarmed sweep: transparency and sleep pins as plain logic
    for (int p = 0; p < 16; p++) begin
      drive(p[3:0], oe_of(p));
      sleep_a_pin = p[0]; sleep_b_pin = p[1];
      core_sleep_out = p[3:2]; core_sleep_oe = p[1:0];
      step(); step(); step();
      chk("R8 clk_en stays high", core_clk_en, 1);
      chk_live("R8 transparent", p[3:0], oe_of(p));
      chk("R8 sleep pins to core", core_sleep_in, p[1:0]);
      chk("R8 sleep drivers", {pad_sleep_out, pad_sleep_oe}, {p[3:2], p[1:0]});
    end
    sleep_a_pin = 0; sleep_b_pin = 0;
    step(); step();

    cfg_sleep_en = 1'b1;
    for (int p = 0; p < 16; p++) begin
      logic [3:0] v, oe;
      v = p[3:0]; oe = oe_of(p);
      drive(v, oe);
      core_sleep_out = 2'b11; core_sleep_oe = 2'b11;
      step();
      chk_live("R8 armed idle live", v, oe);
      chk("R7 sleep drivers masked", {pad_sleep_out, pad_sleep_oe}, 0);
      // raise pin(s): A, B, or both
      sleep_a_pin = (p % 3) != 1;
      sleep_b_pin = (p % 3) != 0;
      #1;
      chk("R7 sleep input masked", core_sleep_in, 0);
      step();
      chk("R1 not yet frozen after one edge", core_clk_en, 1);
      step();
      chk("R1 frozen after second edge", core_clk_en, 0);
      drive(~v, ~oe);
      chk_live("R2 R3 R4 values held", v, oe);
      step(); step();
      chk("R5 frozen in sleep", core_clk_en, 0);
      chk_live("R4 high-Z kept, data held", v, oe);
      sleep_a_pin = 0; sleep_b_pin = 0;
      for (int k = 1; k <= 1 + RC; k++) begin
        step();
        chk("R5 frozen in recovery", core_clk_en, 0);
        chk_live("R6 held in recovery", v, oe);
      end
      step();
      chk("R6 clk_en back", core_clk_en, 1);
      chk_live("R6 live after recovery", ~v, ~oe);
    end

    cfg_sleep_en = 1'b0;
    sleep_a_pin = 1;
    drive(4'h9, 4'h6);
    step(); step(); step();
    chk("R8 disarmed pin high no freeze", core_clk_en, 1);
    chk_live("R8 disarmed live", 4'h9, 4'h6);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule